// File: doc/BRIEF.md
# Sequential Non-Restoring Integer Divider

This block divides one W-bit operand by another and produces a single quotient bit per clock. The partial remainder is never restored. Each step adds or subtracts the divisor depending on the remainder's sign, and one closing cycle fixes up a negative remainder. A select input chooses unsigned or two's-complement signed operation. In signed mode the block divides the magnitudes and then applies the signs: the quotient is truncated toward zero and the remainder takes the dividend's sign.

A caller pulses `start` with the operands while `busy` is low. The block answers with a one-cycle `done` pulse. The quotient, the remainder and the divide-by-zero flag then hold until the next result. A zero divisor skips the iteration and answers on the next edge. A new `start` may arrive in the same cycle that `done` is high.

Top module: `nr_divider`

## Requirements
- R1: In unsigned mode (`is_signed`=0), the results satisfy dividend = quotient*divisor + remainder with remainder < divisor, for any non-zero divisor, including all-ones operands.
- R2: In signed mode (`is_signed`=1, bit W-1 is the sign), the quotient is truncated toward zero and a non-zero remainder has the dividend's sign. The most negative dividend divided by -1 gives the most negative value as quotient and zero as remainder.
- R3: With a non-zero divisor, `done` rises at the (W+2)th rising edge, counting the edge that accepts `start` as the first. That is W iteration edges plus one correction edge after the accepting edge.
- R4: `done` is high for exactly one cycle per accepted operation and is never high together with `busy`.
- R5: A zero divisor sets `div_by_zero`, returns an all-ones quotient and the dividend as remainder, and raises `done` right after the accepting edge. Any later non-zero division clears the flag.
- R6: A `start` seen while `busy` is high is ignored: the running operation finishes with its own operands and the usual latency.
- R7: A `start` given in the cycle where `done` is high is accepted at once as a new operation.
- R8: After reset, `quotient`, `remainder`, `div_by_zero`, `done` and `busy` are all zero. The results hold unchanged in every cycle where `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division with the present operands |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| dividend | input | W | Dividend |
| divisor | input | W | Divisor |
| quotient | output | W | Quotient, valid from `done` |
| remainder | output | W | Remainder, valid from `done` |
| div_by_zero | output | 1 | Last result had a zero divisor |
| done | output | 1 | One-cycle result pulse |
| busy | output | 1 | Iteration or correction in progress |

## Verification
Result delivery and operand acceptance can fall in the same cycle. A new `start` may be accepted while `done` still marks the previous result. The bench provokes this by watching for `done` and driving a fresh operand pair in that very cycle. It then checks three things: the old result was read intact, the new operation takes the full latency, and the new operation returns its own quotient and remainder. A second overlap, a `start` issued mid-iteration, is driven with different operands and judged by the result matching the first operation.

// File: rtl/nr_divider.sv
module nr_divider #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_by_zero,
  output logic         done,
  output logic         busy
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} state_t;
  state_t state;

  logic [W+1:0] part;
  logic [W-1:0] acc;
  logic [W-1:0] dsr;
  logic [CW-1:0] cnt;
  logic neg_q, neg_r;

  wire a_neg = is_signed & dividend[W-1];
  wire b_neg = is_signed & divisor[W-1];
  wire [W-1:0] a_mag = a_neg ? -dividend : dividend;
  wire [W-1:0] b_mag = b_neg ? -divisor : divisor;

  wire [W+1:0] d_ext  = {2'b00, dsr};
  wire [W+1:0] shl    = {part[W:0], acc[W-1]};
  wire [W+1:0] step   = part[W+1] ? shl + d_ext : shl - d_ext;
  wire [W+1:0] fixed  = part[W+1] ? part + d_ext : part;
  wire [W-1:0] r_mag  = fixed[W-1:0];

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      part        <= '0;
      acc         <= '0;
      dsr         <= '0;
      cnt         <= '0;
      neg_q       <= 1'b0;
      neg_r       <= 1'b0;
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (divisor == '0) begin
            quotient    <= '1;
            remainder   <= dividend;
            div_by_zero <= 1'b1;
            done        <= 1'b1;
          end else begin
            part  <= '0;
            acc   <= a_mag;
            dsr   <= b_mag;
            cnt   <= '0;
            neg_q <= a_neg ^ b_neg;
            neg_r <= a_neg;
            state <= S_RUN;
          end
        end
        S_RUN: begin
          part <= step;
          acc  <= {acc[W-2:0], ~step[W+1]};
          cnt  <= cnt + 1'b1;
          if (cnt == LAST) state <= S_FIX;
        end
        S_FIX: begin
          quotient    <= neg_q ? -acc : acc;
          remainder   <= neg_r ? -r_mag : r_mag;
          div_by_zero <= 1'b0;
          done        <= 1'b1;
          state       <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nr_divider_chk.sv
module nr_divider_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] divisor,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         div_by_zero,
  input logic         done,
  input logic         busy
);
  // R5
  zero_div_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0) |=> (done && div_by_zero && quotient == '1));

  // R4
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  // R8
  hold_results_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

  // R7
  start_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start && divisor != '0) |=> busy);

  // R6
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind nr_divider nr_divider_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .divisor(divisor),
  .quotient(quotient), .remainder(remainder), .div_by_zero(div_by_zero),
  .done(done), .busy(busy)
);

// File: tb/test_nr_divider.sv
`timescale 1ns/1ps
module test_nr_divider;
  localparam int W = 64;
  localparam int NV = 11;
  localparam logic [W-1:0] MIN = {1'b1, {(W-1){1'b0}}};

  localparam logic [W-1:0] VA [NV] = '{
    64'd100, '1, '1, 64'd5, MIN,
    -64'sd100, 64'd100, -64'sd100, MIN, {1'b0, {(W-1){1'b1}}},
    64'h1234_5678_9ABC_DEF0};
  localparam logic [W-1:0] VB [NV] = '{
    64'd7, 64'd1, {{(W-1){1'b1}}, 1'b0}, 64'd9, 64'd3,
    64'd7, -64'sd7, -64'sd7, '1, 64'd2,
    64'h1000};
  localparam bit VS [NV] = '{0,0,0,0,0, 1,1,1,1,1, 0};

  logic clk = 0, rst_n = 0, start = 0, is_signed = 0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic [W-1:0] quotient, remainder;
  logic div_by_zero, done, busy;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  nr_divider #(.W(W)) i_nr_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor), .quotient(quotient),
    .remainder(remainder), .div_by_zero(div_by_zero), .done(done), .busy(busy));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit s,
                            output logic [W-1:0] q, output logic [W-1:0] r);
    if (b == '0) begin q = '1; r = a; end
    else if (s && a == MIN && b == '1) begin q = MIN; r = '0; end
    else if (s) begin q = $signed(a) / $signed(b); r = $signed(a) % $signed(b); end
    else begin q = a / b; r = a % b; end
  endtask

  // drive at negedge; returns number of rising edges until done is seen
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input bit s,
                     output int lat);
    dividend = a; divisor = b; is_signed = s; start = 1;
    lat = 0;
    for (int k = 0; k < 200; k++) begin
      @(posedge clk); lat++;
      @(negedge clk); start = 0;
      if (done) break;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    logic [W-1:0] eq, er, q1, r1;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 quotient", quotient, '0);
    chk("R8 remainder", remainder, '0);
    chk("R8 flags", {61'd0, div_by_zero, done, busy}, '0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run(VA[i], VB[i], VS[i], lat);
      expect_div(VA[i], VB[i], VS[i], eq, er);
      chk(VS[i] ? "R2 quotient" : "R1 quotient", quotient, eq);
      chk(VS[i] ? "R2 remainder" : "R1 remainder", remainder, er);
      chk("R3 latency", W'(lat), W'(W + 2));
      chk("R4 busy low at done", {63'd0, busy}, '0);
      @(negedge clk);
      chk("R4 done one cycle", {63'd0, done}, '0);
      chk("R8 hold quotient", quotient, eq);
    end

    // R5 zero divisor
    run(64'd1234, '0, 0, lat);
    chk("R5 latency", W'(lat), W'(1));
    chk("R5 flag", {63'd0, div_by_zero}, 64'd1);
    chk("R5 quotient", quotient, '1);
    chk("R5 remainder", remainder, 64'd1234);
    run(64'd9, 64'd2, 0, lat);
    chk("R5 flag cleared", {63'd0, div_by_zero}, '0);

    // R6 start while busy
    dividend = 64'd1000; divisor = 64'd3; is_signed = 0; start = 1;
    @(posedge clk); @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    dividend = 64'd77; divisor = 64'd5; start = 1;
    @(negedge clk); start = 0;
    dividend = 64'd1000; divisor = 64'd3;
    lat = 12;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk); lat++;
      if (done) break;
    end
    chk("R6 quotient", quotient, 64'd333);
    chk("R6 remainder", remainder, 64'd1);
    chk("R6 latency", W'(lat), W'(W + 2));

    // R7 start on the done cycle
    q1 = quotient; r1 = remainder;
    run(-64'sd50, 64'd8, 1, lat);
    chk("R7 first quotient", quotient, -64'sd6);
    chk("R7 first remainder", remainder, -64'sd2);
    run(64'd81, 64'd9, 0, lat);
    chk("R7 back-to-back latency", W'(lat), W'(W + 2));
    chk("R7 back-to-back quotient", quotient, 64'd9);
    chk("R7 back-to-back remainder", remainder, 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule